// File: doc/BRIEF.md
# Page-Offset-Indexed L1 Data Cache Lookup

This block is the lookup and refill core of a 16 KiB, four-way set-associative level-one data cache with 64-byte lines. It takes only the untranslated page-offset part of a virtual address. When a request is accepted, it starts reading the tag, valid and data arrays of all four ways at once. In parallel, an external translation unit works out the physical frame number. When that frame number arrives, it is compared against the four tags already read out. One cycle later the block reports hit or miss, which way hit, and the addressed word of the line.

Each way holds exactly one page worth of lines, so the set is fixed by address bits that translation never changes. Any two virtual aliases of one physical line therefore always fall in the same set, and the block has no alias logic. On a miss the block asks the next memory level for the whole physical line and accepts no new lookup until the line comes back. It places the line in the lowest invalid way, or in the way chosen by a per-set tree pseudo-LRU when all ways are valid. A translation fault ends the lookup with no hit and no refill. A single-cycle invalidate-all input empties the cache.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset, every line is invalid, `req_ready` is 1, and `rsp_valid` and `fill_req` are 0.
- R2: The set is `req_off[PAGE_BITS-1:OFF_BITS]`, and the arrays are read in the cycle a request is accepted (`req_valid` and `req_ready` both high). A line cached under one frame number is found from any request carrying the same page offset.
- R3: Exactly one cycle after an accepted translation strobe, `rsp_valid` is 1 for one cycle. `rsp_hit` is 1 when a valid way of the set holds a tag equal to `xlat_pfn` and no fault is reported. On a hit, `rsp_data` is word `req_off[OFF_BITS-1:$clog2(WORD_BITS/8)]` of the line, where word 0 is the least significant bits of the filled line.
- R4: At most one way matches. `rsp_way` is one-hot for the hitting way (bit i means way i) and is 0 on a miss.
- R5: On a miss without a fault, `fill_req` rises in the same cycle as the response and stays high until `fill_valid` is seen. `fill_addr` is `{pfn, set}` and stays stable while `fill_req` is high.
- R6: `req_ready` is low from the cycle after acceptance until the response (hit or fault) or until the fill completes. A `req_valid` while not ready, and an `xlat_valid` while no lookup waits for translation, have no effect.
- R7: A fill writes the line and its tag into the lowest-numbered invalid way of the set. If all four ways are valid, it writes the pseudo-LRU victim.
- R8: The pseudo-LRU uses three bits per set, all 0 after reset. The victim is way 0 or 1 when the root bit is 0 (the left bit picks way 1 when set) and way 2 or 3 when the root bit is 1 (the right bit picks way 3 when set). Each hit and each fill points the tree away from the accessed way.
- R9: A lookup whose translation reports a fault responds with `rsp_hit`=0 and `rsp_way`=0. It raises no fill and leaves the pseudo-LRU state unchanged.
- R10: `inval_all` clears every valid bit and every pseudo-LRU bit in one cycle. Later lookups miss and refill from way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval_all | input | 1 | Invalidate every line and reset replacement state |
| req_valid | input | 1 | Lookup request |
| req_off | input | PAGE_BITS | Untranslated page-offset bits of the virtual address |
| req_ready | output | 1 | Block can accept a lookup |
| xlat_valid | input | 1 | Translation result strobe |
| xlat_pfn | input | PFN_BITS | Physical frame number |
| xlat_fault | input | 1 | Translation faulted |
| rsp_valid | output | 1 | Lookup result strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 4 | One-hot hitting way |
| rsp_data | output | WORD_BITS | Addressed word on a hit |
| fill_req | output | 1 | Line fill requested |
| fill_addr | output | PFN_BITS+PAGE_BITS-OFF_BITS | Physical line address of the fill |
| fill_valid | input | 1 | Fill line delivered |
| fill_data | input | 8<<OFF_BITS | Whole line from the next level |

## Verification
The bench builds the block with 256-byte pages, 16-byte lines (16 sets) and 32-bit words, with 8-bit frame numbers. This keeps the reference model small while exercising four word positions per line, set sweeps that cover every set, and repeated conflicts on one set. With few frame numbers in play, the pseudo-LRU victim order can be followed over long hit and refill runs. The tests vary translation and fill latency, and they also drive requests during stalls, faults and invalidation.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int WAYS = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_FILL} lk_state_t;

  function automatic logic [1:0] plru_victim(input logic [2:0] t);
    if (t[0]) return t[2] ? 2'd3 : 2'd2;
    return t[1] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction

  function automatic logic [1:0] pick_way(input logic [3:0] vld, input logic [2:0] t);
    if (!vld[0]) return 2'd0;
    if (!vld[1]) return 2'd1;
    if (!vld[2]) return 2'd2;
    if (!vld[3]) return 2'd3;
    return plru_victim(t);
  endfunction

  function automatic logic [1:0] way_index(input logic [3:0] oh);
    return {oh[3] | oh[2], oh[3] | oh[1]};
  endfunction
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store import vipt_pkg::*; #(
  parameter int SET_BITS = 6,
  parameter int TAG_BITS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inval_all,
  input  logic                rd_en,
  input  logic [SET_BITS-1:0] rd_set,
  input  logic [TAG_BITS-1:0] cmp_tag,
  output logic [WAYS-1:0]     match,
  input  logic                wr_en,
  input  logic [SET_BITS-1:0] wr_set,
  input  logic [1:0]          wr_way,
  input  logic [TAG_BITS-1:0] wr_tag,
  output logic [WAYS-1:0]     live_valid
);
  localparam int SETS = 1 << SET_BITS;

  logic [WAYS-1:0]     valid_q [SETS];
  logic [TAG_BITS-1:0] tag_mem [SETS][WAYS];
  logic [WAYS-1:0]     rd_valid_q;
  logic [TAG_BITS-1:0] rd_tag_q [WAYS];
  logic                any_valid;

  always_ff @(posedge clk) begin
    if (!rst_n || inval_all) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_set][wr_way] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || inval_all) rd_valid_q <= '0;
    else if (rd_en)          rd_valid_q <= valid_q[rd_set];
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      for (int w = 0; w < WAYS; w++) rd_tag_q[w] <= tag_mem[rd_set][w];
    end
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = rd_valid_q[w] && (rd_tag_q[w] == cmp_tag);
    end
  endgenerate

  assign live_valid = valid_q[wr_set];

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
  end

  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match) <= 1);
  assert_inval_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> !any_valid);
  assert_fill_sets_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inval_all) |=> valid_q[$past(wr_set)][$past(wr_way)]);
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store import vipt_pkg::*; #(
  parameter int SET_BITS  = 6,
  parameter int LINE_W    = 512,
  parameter int WORD_BITS = 64,
  parameter int WSEL_BITS = 3
) (
  input  logic                            clk,
  input  logic                            rd_en,
  input  logic [SET_BITS-1:0]             rd_set,
  input  logic [WSEL_BITS-1:0]            rd_word,
  output logic [WAYS-1:0][WORD_BITS-1:0]  rd_words,
  input  logic                            wr_en,
  input  logic [SET_BITS-1:0]             wr_set,
  input  logic [1:0]                      wr_way,
  input  logic [LINE_W-1:0]               wr_line
);
  localparam int SETS = 1 << SET_BITS;

  logic [LINE_W-1:0] line_mem [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) line_mem[wr_set][wr_way] <= wr_line;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      for (int w = 0; w < WAYS; w++)
        rd_words[w] <= line_mem[rd_set][w][int'(rd_word) * WORD_BITS +: WORD_BITS];
    end
  end
endmodule

// File: rtl/vipt_plru.sv
module vipt_plru import vipt_pkg::*; #(
  parameter int SET_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inval_all,
  input  logic [SET_BITS-1:0] set_sel,
  output logic [2:0]          tree,
  input  logic                upd_en,
  input  logic [1:0]          upd_way
);
  localparam int SETS = 1 << SET_BITS;

  logic [2:0] tree_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n || inval_all) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= 3'b000;
    end else if (upd_en) begin
      tree_q[set_sel] <= plru_touch(tree_q[set_sel], upd_way);
    end
  end

  assign tree = tree_q[set_sel];

  assert_touch_root_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !inval_all) |=> (tree_q[$past(set_sel)][0] == !$past(upd_way[1])));
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup import vipt_pkg::*; #(
  parameter int PAGE_BITS = 12,
  parameter int OFF_BITS  = 6,
  parameter int PFN_BITS  = 20,
  parameter int WORD_BITS = 64
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  inval_all,
  input  logic                                  req_valid,
  input  logic [PAGE_BITS-1:0]                  req_off,
  output logic                                  req_ready,
  input  logic                                  xlat_valid,
  input  logic [PFN_BITS-1:0]                   xlat_pfn,
  input  logic                                  xlat_fault,
  output logic                                  rsp_valid,
  output logic                                  rsp_hit,
  output logic [3:0]                            rsp_way,
  output logic [WORD_BITS-1:0]                  rsp_data,
  output logic                                  fill_req,
  output logic [PFN_BITS+PAGE_BITS-OFF_BITS-1:0] fill_addr,
  input  logic                                  fill_valid,
  input  logic [(8<<OFF_BITS)-1:0]              fill_data
);
  localparam int SET_BITS  = PAGE_BITS - OFF_BITS;
  localparam int LINE_W    = 8 << OFF_BITS;
  localparam int WB_BITS   = $clog2(WORD_BITS / 8);
  localparam int WSEL_BITS = OFF_BITS - WB_BITS;
  localparam int LADDR_W   = PFN_BITS + SET_BITS;

  lk_state_t                     state_q;
  logic [SET_BITS-1:0]           set_q;
  logic [PFN_BITS-1:0]           pfn_q;
  logic [WAYS-1:0]               match;
  logic [WAYS-1:0]               live_valid;
  logic [WAYS-1:0][WORD_BITS-1:0] way_words;
  logic [2:0]                    tree;
  logic [WORD_BITS-1:0]          hit_data;

  // named internal events
  logic       req_accept, xlat_accept, lookup_hit, lookup_miss, fill_done;
  logic [1:0] hit_idx, fill_way, touch_way;
  logic       touch_en;

  assign req_ready   = (state_q == ST_IDLE);
  assign req_accept  = req_valid && req_ready;
  assign xlat_accept = xlat_valid && (state_q == ST_WAIT);
  assign lookup_hit  = xlat_accept && !xlat_fault && (|match);
  assign lookup_miss = xlat_accept && !xlat_fault && !(|match);
  assign fill_done   = fill_valid && (state_q == ST_FILL);
  assign hit_idx     = way_index(match);
  assign fill_way    = pick_way(live_valid, tree);
  assign touch_en    = lookup_hit || fill_done;
  assign touch_way   = fill_done ? fill_way : hit_idx;
  assign fill_req    = (state_q == ST_FILL);

  vipt_tag_store #(.SET_BITS(SET_BITS), .TAG_BITS(PFN_BITS)) u_tags (
    .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
    .rd_en(req_accept), .rd_set(req_off[PAGE_BITS-1:OFF_BITS]),
    .cmp_tag(xlat_pfn), .match(match),
    .wr_en(fill_done), .wr_set(set_q), .wr_way(fill_way), .wr_tag(pfn_q),
    .live_valid(live_valid)
  );

  vipt_data_store #(.SET_BITS(SET_BITS), .LINE_W(LINE_W), .WORD_BITS(WORD_BITS),
                    .WSEL_BITS(WSEL_BITS)) u_data (
    .clk(clk), .rd_en(req_accept), .rd_set(req_off[PAGE_BITS-1:OFF_BITS]),
    .rd_word(req_off[OFF_BITS-1:WB_BITS]), .rd_words(way_words),
    .wr_en(fill_done), .wr_set(set_q), .wr_way(fill_way), .wr_line(fill_data)
  );

  vipt_plru #(.SET_BITS(SET_BITS)) u_plru (
    .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
    .set_sel(set_q), .tree(tree), .upd_en(touch_en), .upd_way(touch_way)
  );

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_data = hit_data | way_words[w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      set_q   <= '0;
      pfn_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_accept) begin
          state_q <= ST_WAIT;
          set_q   <= req_off[PAGE_BITS-1:OFF_BITS];
        end
        ST_WAIT: if (xlat_accept) begin
          state_q <= lookup_miss ? ST_FILL : ST_IDLE;
          pfn_q   <= xlat_pfn;
        end
        ST_FILL: if (fill_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= xlat_accept;
      rsp_hit   <= lookup_hit;
      rsp_way   <= lookup_hit ? match : '0;
      if (lookup_hit) rsp_data <= hit_data;
    end
  end

  assign fill_addr = LADDR_W'({pfn_q, set_q});

  assert_rsp_after_xlat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(xlat_valid));
  assert_way_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ? ($countones(rsp_way) == 1) : (rsp_way == '0)));
  assert_fill_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));
  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> !req_ready);
  assert_fault_no_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_accept && xlat_fault) |=> (!fill_req && !rsp_hit));
endmodule

// File: tb/vipt_l1_lookup_bench.sv
module vipt_l1_lookup_bench;
  localparam int PB = 8;
  localparam int OB = 4;
  localparam int PF = 8;
  localparam int WDB = 32;
  localparam int SB = PB - OB;
  localparam int NS = 1 << SB;
  localparam int LW = 8 << OB;
  localparam int AW = PF + SB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inval_all = 1'b0;
  logic req_valid = 1'b0;
  logic [PB-1:0] req_off = '0;
  logic req_ready;
  logic xlat_valid = 1'b0;
  logic [PF-1:0] xlat_pfn = '0;
  logic xlat_fault = 1'b0;
  logic rsp_valid, rsp_hit;
  logic [3:0] rsp_way;
  logic [WDB-1:0] rsp_data;
  logic fill_req;
  logic [AW-1:0] fill_addr;
  logic fill_valid = 1'b0;
  logic [LW-1:0] fill_data = '0;

  always #2.5 clk = ~clk;

  vipt_l1_lookup #(.PAGE_BITS(PB), .OFF_BITS(OB), .PFN_BITS(PF), .WORD_BITS(WDB)) u_vipt_l1_lookup (
    .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
    .req_valid(req_valid), .req_off(req_off), .req_ready(req_ready),
    .xlat_valid(xlat_valid), .xlat_pfn(xlat_pfn), .xlat_fault(xlat_fault),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_data(rsp_data),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data)
  );

  int total = 0;
  int bad = 0;

  // behavioural reference state
  bit m_vld [NS][4];
  int m_tag [NS][4];
  logic [LW-1:0] m_line [NS][4];
  int m_root [NS], m_left [NS], m_right [NS];

  // expectations for the next sampled cycle
  bit exp_ready = 1'b1, exp_rv = 1'b0, exp_hit = 1'b0, exp_fill = 1'b0;
  logic [3:0] exp_way = '0;
  logic [WDB-1:0] exp_data = '0;
  logic [AW-1:0] exp_faddr = '0;
  string scen = "R1";

  task automatic chk(string r, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s) %s: actual=%0h expected=%0h", r, scen, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    chk("R6", "req_ready", LW'(req_ready), LW'(exp_ready));
    chk("R3", "rsp_valid", LW'(rsp_valid), LW'(exp_rv));
    chk("R5", "fill_req", LW'(fill_req), LW'(exp_fill));
    if (exp_rv) begin
      chk("R3", "rsp_hit", LW'(rsp_hit), LW'(exp_hit));
      chk("R4", "rsp_way", LW'(rsp_way), LW'(exp_way));
      if (exp_hit) chk("R3", "rsp_data", LW'(rsp_data), LW'(exp_data));
    end
    if (exp_fill) chk("R5", "fill_addr", LW'(fill_addr), LW'(exp_faddr));
  endtask

  function automatic logic [LW-1:0] mk_line(int pfn, int s, int salt);
    logic [LW-1:0] l;
    for (int w = 0; w < LW / WDB; w++)
      l[w*WDB +: WDB] = {8'(pfn), 8'(s), 8'(salt), 8'(w)};
    return l;
  endfunction

  function automatic void m_touch(int s, int w);
    m_root[s] = (w < 2) ? 1 : 0;
    if (w < 2) m_left[s] = (w == 0) ? 1 : 0;
    else       m_right[s] = (w == 2) ? 1 : 0;
  endfunction

  function automatic int m_victim(int s);
    for (int w = 0; w < 4; w++) if (!m_vld[s][w]) return w;
    if (m_root[s] == 0) return m_left[s];
    return 2 + m_right[s];
  endfunction

  function automatic void m_clear();
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
      m_root[s] = 0; m_left[s] = 0; m_right[s] = 0;
    end
  endfunction

  int salt = 1;

  task automatic do_fill(int s, int pfn, int lat, bit hold_req);
    int vw;
    if (hold_req) begin
      req_valid = 1'b1;                 // must be ignored (R6)
      req_off = 8'(((s + 1) % NS) << OB);
      xlat_valid = 1'b1;                // not waiting for translation: ignored (R6)
    end
    repeat (lat) tick();
    req_valid = 1'b0;
    xlat_valid = 1'b0;
    vw = m_victim(s);
    salt++;
    fill_valid = 1'b1;
    fill_data = mk_line(pfn, s, salt);
    exp_fill = 1'b0;
    exp_ready = 1'b1;
    tick();
    fill_valid = 1'b0;
    m_vld[s][vw] = 1'b1;     // R7 placement
    m_tag[s][vw] = pfn;
    m_line[s][vw] = mk_line(pfn, s, salt);
    m_touch(s, vw);          // R8 update on fill
  endtask

  task automatic lookup(int s, int word, int pfn, bit fault, int lat, int flat, bit hold_req);
    int hw;
    hw = -1;
    req_valid = 1'b1;
    req_off = 8'((s << OB) | (word << 2) | 1);
    exp_ready = 1'b0;
    exp_rv = 1'b0;
    tick();
    req_valid = 1'b0;
    repeat (lat) tick();
    for (int w = 0; w < 4; w++) if (m_vld[s][w] && m_tag[s][w] == pfn) hw = w;
    xlat_valid = 1'b1;
    xlat_pfn = 8'(pfn);
    xlat_fault = fault;
    exp_rv = 1'b1;
    exp_hit = (hw >= 0) && !fault;
    exp_way = exp_hit ? 4'(1 << hw) : 4'b0;
    exp_data = exp_hit ? m_line[s][hw][word*WDB +: WDB] : '0;
    exp_fill = (hw < 0) && !fault;
    exp_faddr = AW'((pfn << SB) | s);
    exp_ready = !exp_fill;
    tick();
    xlat_valid = 1'b0;
    xlat_fault = 1'b0;
    exp_rv = 1'b0;
    if (exp_hit) m_touch(s, hw);       // R8 update on hit; R9 fault leaves it
    if (exp_fill) do_fill(s, pfn, flat, hold_req);
  endtask

  task automatic invalidate;
    inval_all = 1'b1;
    tick();
    inval_all = 1'b0;
    m_clear();
  endtask

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    scen = "R1";
    tick();                                   // R1 reset state
    chk("R1", "idle after reset", LW'({req_ready, rsp_valid, fill_req}), LW'(3'b100));

    scen = "R6";                              // stray translation strobe while idle
    xlat_valid = 1'b1; xlat_pfn = 8'h11;
    tick();
    xlat_valid = 1'b0;
    tick();

    scen = "R5";
    lookup(3, 2, 8'h11, 1'b0, 0, 2, 1'b0);    // miss, fill into way 0
    scen = "R3";
    lookup(3, 2, 8'h11, 1'b0, 0, 0, 1'b0);    // hit way 0
    lookup(3, 0, 8'h11, 1'b0, 3, 0, 1'b0);    // hit, later translation, word 0
    scen = "R7";
    lookup(3, 1, 8'h22, 1'b0, 1, 0, 1'b0);    // way 1
    lookup(3, 3, 8'h33, 1'b0, 0, 1, 1'b0);    // way 2
    lookup(3, 3, 8'h44, 1'b0, 2, 3, 1'b0);    // way 3
    scen = "R4";
    for (int i = 0; i < 4; i++) lookup(3, i, 8'h11 * (i + 1), 1'b0, i, 0, 1'b0);
    scen = "R8";
    lookup(3, 1, 8'h22, 1'b0, 0, 0, 1'b0);
    lookup(3, 2, 8'h55, 1'b0, 0, 1, 1'b0);    // full set: tree victim
    lookup(3, 2, 8'h55, 1'b0, 0, 0, 1'b0);
    lookup(3, 0, 8'h66, 1'b0, 1, 0, 1'b0);
    scen = "R9";
    lookup(3, 0, 8'h55, 1'b1, 0, 0, 1'b0);    // fault on cached frame
    lookup(7, 0, 8'h77, 1'b1, 2, 0, 1'b0);    // fault on uncached frame: no fill
    lookup(3, 1, 8'h99, 1'b0, 0, 0, 1'b0);    // victim shows tree untouched by faults
    scen = "R6";
    lookup(9, 1, 8'h12, 1'b0, 0, 4, 1'b1);    // requests held during refill stall
    lookup(9, 1, 8'h12, 1'b0, 0, 0, 1'b0);
    scen = "R2";
    for (int s = 0; s < NS; s++) lookup(s, s % 4, 8'(s * 3 + 1), 1'b0, s % 3, s % 2, 1'b0);
    for (int s = 0; s < NS; s++) lookup(s, (s + 1) % 4, 8'(s * 3 + 1), 1'b0, 0, 0, 1'b0);
    scen = "R10";
    invalidate();
    tick();
    lookup(3, 2, 8'h55, 1'b0, 0, 0, 1'b0);    // miss after invalidate, refill way 0
    lookup(3, 2, 8'h55, 1'b0, 0, 0, 1'b0);
    lookup(0, 1, 8'h01, 1'b0, 0, 0, 1'b0);
    scen = "R8";
    begin
      int lcg;
      lcg = 7;
      for (int i = 0; i < 60; i++) begin
        lcg = (lcg * 13 + 5) % 97;
        lookup(5, lcg % 4, 8'h80 + (lcg % 6), 1'b0, lcg % 3, lcg % 2, 1'b0);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog (%s): actual=hung expected=done", scen);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule